// File: doc/BRIEF.md
# Time-of-Day Counter with Trimmable Increment

This block keeps a free-running 64-bit time value for precision timestamping. At each step it adds a programmable increment to the time. Software changes the increment to trim the counter's rate. A period field in the same register slows the schedule, so that the increment is added once every P clock cycles instead of once per cycle. The accumulated time is never saturated. It wraps modulo 2^64.

Software reaches the counter through a small word-addressed register port.

- Address 0 is the low time word.
- Address 1 is the high time word.
- Address 2 is the increment register.

A write to the low word is held in a staging register. A later write to the high word loads both halves into the counter at once. Reads return the live time, so a reader that needs a coherent 64-bit value reads high, then low, then high again. It repeats the low read when the two high values differ.

The full 64-bit time is also driven on a parallel output, for capture and trigger logic in the same clock domain. A build variant with `PERIOD_EN = 0` widens the increment field and drops the period field. That variant adds the increment on every cycle.

Top module: `tod_counter`

## Requirements
- R1: After reset, the time is zero, and the increment register reads zero (increment 0, period 0).
- R2: The increment register at address 2 holds the increment in bits [INC_W-1:0] and the period in bits [31:INC_W]. With the defaults these are bits [23:0] and [31:24]. A read at address 2 returns the last value written.
- R3: With no write in a cycle, the time either holds or grows by exactly the increment. With period P >= 2 the increment is added once every P cycles. With P = 0 or P = 1 it is added every cycle. With increment 0 the time holds.
- R4: A write to the increment register restarts the prescaler. With period P, the first addition happens on the P-th clock edge after the write edge.
- R5: A write to the increment register leaves the accumulated time unchanged. No addition is made on the write edge.
- R6: A write to address 0 only stages the low word. The time value is not changed by it.
- R7: A write to address 1 loads {written word, staged low word} into the time on the write edge. It also restarts the prescaler, and no addition is made on that edge.
- R8: The time wraps modulo 2^64. FFFFFFFF_FFFFFFF8 plus 0x10 gives 00000000_00000008.
- R9: Address 0 reads the live low time word and address 1 the live high word. Address 3 reads zero. `time_now` carries the full 64-bit time. A high/low/high read sequence with a repeated low read returns a coherent value across a carry into the high word.
- R10: A write to address 3 changes neither the time nor the increment register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 low time, 1 high time, 2 increment, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| time_now | output | 64 | Current 64-bit time |

## Verification
The bench builds the block with its default parameters: a 24-bit increment and an 8-bit period field. Because the period field is real in this build, the bench can exercise periods 0, 1, 2, 3 and 4 and observe the prescaler restart after increment and high-word writes. The 64-bit counter is loaded just below its limit to show the wrap. A load at the top of the low word, with an increment of 2 per cycle, forces a carry in the middle of a three-step register read.

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int INC_W     = 24,
  parameter bit PERIOD_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [63:0] time_now
);

  localparam int PER_W = PERIOD_EN ? (32 - INC_W) : 1;

  logic [63:0]      time_q;
  logic [INC_W-1:0] inc_q;
  logic [31:0]      lo_stage;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] pre_q;
  logic [31:0]      inc_rd;
  logic             tick;

  wire wr_lo  = reg_wr && (reg_addr == 2'd0);
  wire wr_hi  = reg_wr && (reg_addr == 2'd1);
  wire wr_inc = reg_wr && (reg_addr == 2'd2);

  generate
    if (PERIOD_EN) begin : g_per
      always_ff @(posedge clk) begin
        if (!rst_n)      per_q <= '0;
        else if (wr_inc) per_q <= reg_wdata[31:INC_W];
      end

      always_ff @(posedge clk) begin
        if (!rst_n)                pre_q <= '0;
        else if (wr_inc || wr_hi)  pre_q <= '0;
        else if (tick)             pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
      end

      assign tick   = (per_q < PER_W'(2)) || (pre_q == per_q - 1'b1);
      assign inc_rd = {per_q, inc_q};
    end else begin : g_noper
      assign per_q  = '0;
      assign pre_q  = '0;
      assign tick   = 1'b1;
      assign inc_rd = 32'(inc_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      inc_q <= '0;
    else if (wr_inc) inc_q <= reg_wdata[INC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     lo_stage <= '0;
    else if (wr_lo) lo_stage <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                time_q <= '0;
    else if (wr_hi)            time_q <= {reg_wdata, lo_stage};
    else if (!wr_inc && tick)  time_q <= time_q + {{(64-INC_W){1'b0}}, inc_q};
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = time_q[31:0];
      2'd1:    reg_rdata = time_q[63:32];
      2'd2:    reg_rdata = inc_rd;
      default: reg_rdata = '0;
    endcase
  end

  assign time_now = time_q;

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int INC_W = 24,
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [63:0]      time_now,
  input logic [INC_W-1:0] inc_q,
  input logic [PER_W-1:0] per_q
);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (time_now == $past(time_now)) ||
                (time_now == $past(time_now) + {{(64-INC_W){1'b0}}, $past(inc_q)}));

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && per_q >= PER_W'(2) && time_now != $past(time_now)) |=> $stable(time_now));

  p_trim_keeps_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> (time_now == $past(time_now)));

  p_lo_staged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && inc_q == '0) |=> $stable(time_now));

  p_hi_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (time_now[63:32] == $past(reg_wdata)));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && inc_q == '0) |=> $stable(time_now) && $stable(inc_q) && $stable(per_q));

endmodule

bind tod_counter tod_counter_chk #(.INC_W(INC_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .time_now(time_now), .inc_q(inc_q), .per_q(per_q)
);

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_now;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  tod_counter u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_now(time_now)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 time after reset", time_now, 64'd0);
    rd(2'd0, d); chk("R1 low word", 64'(d), 64'd0);
    rd(2'd1, d); chk("R1 high word", 64'(d), 64'd0);
    rd(2'd2, d); chk("R1 increment reg", 64'(d), 64'd0);
    step(5);
    chk("R3 zero increment holds", time_now, 64'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd2, 32'h0280_0000);
    rd(2'd2, d); chk("R2 readback a", 64'(d), 64'h0280_0000);
    wr(2'd2, 32'hFFAB_CDEF);
    rd(2'd2, d); chk("R2 readback b", 64'(d), 64'hFFAB_CDEF);
    rd(2'd3, d); chk("R9 addr3 reads zero", 64'(d), 64'd0);
  endtask

  task automatic t_period;
    logic [63:0] t0;
    wr(2'd2, {8'd4, 24'd5});
    t0 = time_now;
    for (int i = 1; i <= 3; i++) begin
      step(1); chk("R4 no add before P edges", time_now, t0);
    end
    step(1); chk("R3 add on 4th edge", time_now, t0 + 64'd5);
    step(3); chk("R3 hold within period", time_now, t0 + 64'd5);
    step(1); chk("R3 second add P=4", time_now, t0 + 64'd10);
    wr(2'd2, {8'd1, 24'd3});
    t0 = time_now;
    step(1); chk("R3 P=1 first", time_now, t0 + 64'd3);
    step(1); chk("R3 P=1 second", time_now, t0 + 64'd6);
    wr(2'd2, {8'd0, 24'd9});
    t0 = time_now;
    step(1); chk("R3 P=0 every cycle", time_now, t0 + 64'd9);
  endtask

  task automatic t_retrim;
    logic [63:0] pre;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = {8'd2, 24'd100};
    pre = time_now;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R5 retrim keeps time", time_now, pre);
    step(1); chk("R4 P=2 no add first edge", time_now, pre);
    step(1); chk("R5 new increment used", time_now, pre + 64'd100);
  endtask

  task automatic t_lo_only;
    logic [63:0] t0;
    logic [31:0] d;
    wr(2'd2, 32'd0);
    t0 = time_now;
    wr(2'd0, 32'h1234_5678);
    chk("R6 low write staged only", time_now, t0);
    rd(2'd0, d); chk("R6 live low unchanged", 64'(d), 64'(t0[31:0]));
    wr(2'd3, 32'hDEAD_BEEF);
    chk("R10 addr3 write time", time_now, t0);
    rd(2'd2, d); chk("R10 addr3 write incr", 64'(d), 64'd0);
  endtask

  task automatic t_load;
    wr(2'd2, {8'd3, 24'd7});
    wr(2'd1, 32'h0000_ABCD);
    chk("R7 pair loaded", time_now, 64'h0000_ABCD_1234_5678);
    step(2); chk("R7 prescaler restarted", time_now, 64'h0000_ABCD_1234_5678);
    step(1); chk("R7 add on 3rd edge", time_now, 64'h0000_ABCD_1234_567F);
  endtask

  task automatic t_wrap;
    wr(2'd2, {8'd1, 24'h10});
    wr(2'd0, 32'hFFFF_FFF8);
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R8 near top", time_now, 64'hFFFF_FFFF_FFFF_FFF8);
    step(1); chk("R8 wraps", time_now, 64'h0000_0000_0000_0008);
  endtask

  task automatic t_read;
    logic [31:0] h1, h2, lo;
    wr(2'd2, {8'd1, 24'd2});
    wr(2'd0, 32'hFFFF_FFFC);
    wr(2'd1, 32'h0);
    rd(2'd1, h1);
    step(1); rd(2'd0, lo);
    step(1); rd(2'd1, h2);
    if (h1 != h2) begin
      step(1); rd(2'd0, lo);
    end
    chk("R9 high samples differ", 64'(h1 != h2), 64'd1);
    chk("R9 coherent read", {h2, lo}, 64'h1_0000_0002);
    chk("R9 parallel output", time_now, 64'h1_0000_0002);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_period();
    t_retrim();
    t_lo_only();
    t_load();
    t_wrap();
    t_read();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule